// File: doc/BRIEF.md
# Receive Word Buffer with Occupancy Status

This block stores data words that an upstream serial-bus receiver has already decoded and accepted. Each accepted word arrives with a one-cycle write strobe. The host side removes words in arrival order with a one-cycle pop strobe. The popped word appears on a registered data output.

Next to the data path the block drives a data-ready flag and three occupancy indicators. The vacancy bit is high only while nothing is stored and drops as soon as one word is held. The half bit is high at sixteen or more words, and the full bit is high when every slot is occupied.

A word that arrives while the buffer is full is not lost. It replaces the most recently written entry, and every older entry stays intact. The current occupancy is also given as a binary count.

Top module: `rx_word_buffer`

## Requirements
- R1: After a synchronous active-low reset, word_count is 0, data_rdy is 0, sts_vacant is 1, and sts_half and sts_full are 0.
- R2: Every write strobe sets data_rdy to 1 from the next clock edge, whether the buffer had room or was full.
- R3: sts_vacant is 0 whenever at least one word is stored, and 1 only when word_count is 0.
- R4: Words leave in arrival order. The popped word is on rd_data from the clock edge that registers the pop strobe.
- R5: data_rdy returns to 0 when a pop removes the last stored word and no write happens in that cycle.
- R6: A pop strobe while the buffer is empty is ignored: rd_data keeps its previous value and word_count does not change.
- R7: sts_half is 1 exactly when word_count is 16 or more (DEPTH/2).
- R8: sts_full is 1 exactly when word_count equals 32 (DEPTH).
- R9: A write while full with no pop replaces the newest stored word (the 32nd slot in arrival order), keeps the other 31, and leaves word_count at 32.
- R10: A write and a pop in the same cycle while 1 to 31 words are stored leave word_count unchanged. The oldest word goes out and the new word joins the tail.
- R11: A write and a pop in the same cycle while full deliver the oldest word, append the new word as the newest, and keep word_count at 32 without replacing anything.
- R12: word_count is a 6-bit binary count of stored words and never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | One-cycle strobe per accepted word |
| wr_data | input | 32 | Word to store |
| rd_stb | input | 1 | One-cycle pop strobe |
| rd_data | output | 32 | Most recently popped word |
| word_count | output | 6 | Number of stored words |
| data_rdy | output | 1 | Set by any write, cleared when a pop empties the buffer |
| sts_vacant | output | 1 | High when empty, low while any word is held |
| sts_half | output | 1 | High at 16 or more stored words |
| sts_full | output | 1 | High when all 32 slots are occupied |

## Verification
The bench builds the block with its default 32-bit words and 32 slots. With these values both thresholds can be reached in a few dozen strobes, so each step across 15/16 and 31/32 is checked. At that size the overwrite-while-full and simultaneous-at-full cases, as well as pointer wrap-around after a full drain, can be driven and fully drained back out for an ordered comparison.

// File: rtl/rxb_pkg.sv
// Package: shared types for the receive word buffer.
// Assumes nothing beyond IEEE 1800-2017.
package rxb_pkg;

    // Decoded buffer operation for one clock cycle.
    typedef struct packed {
        logic push;    // append at the tail
        logic over;    // replace the newest entry (buffer full, no pop)
        logic pop;     // remove the oldest entry
    } rxb_op_t;

    // Decode the strobes against the current occupancy.
    function automatic rxb_op_t rxb_decode(input logic wr, input logic rd,
                                           input logic is_empty, input logic is_full);
        rxb_op_t op;
        op.pop  = rd && !is_empty;
        op.push = wr && (!is_full || op.pop);
        op.over = wr && is_full && !op.pop;
        return op;
    endfunction

endpackage

// File: rtl/rxb_ptr_ctrl.sv
// Module: rxb_ptr_ctrl
// Keeps read and write pointers and the occupancy count. It decodes the
// strobes into push, overwrite and pop, and gives the memory its write
// address. Assumes DEPTH is a power of two, so the pointers wrap by overflow.
module rxb_ptr_ctrl
    import rxb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    output rxb_op_t          op,
    output logic [PTR_W-1:0] waddr,
    output logic [PTR_W-1:0] raddr,
    output logic [CNT_W-1:0] cnt_q
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [PTR_W-1:0] wptr_q;
    logic [PTR_W-1:0] rptr_q;
    logic             is_empty;
    logic             is_full;

    // Occupancy conditions from the registered count.
    always_comb begin
        is_empty = (cnt_q == '0);
        is_full  = (cnt_q == CNT_FULL);
    end

    // Decode strobes into the cycle's operation.
    always_comb begin
        op = rxb_decode(wr_stb, rd_stb, is_empty, is_full);
    end

    // Write address: tail slot for a push, newest slot for an overwrite.
    always_comb begin
        if (op.over) begin
            waddr = wptr_q - PTR_W'(1);
        end else begin
            waddr = wptr_q;
        end
        raddr = rptr_q;
    end

    // Advance the pointers and update the count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (op.push) begin
                wptr_q <= wptr_q + PTR_W'(1);
            end
            if (op.pop) begin
                rptr_q <= rptr_q + PTR_W'(1);
            end
            case ({op.push, op.pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/rxb_store.sv
// Module: rxb_store
// Word storage with one write port and a registered read port. The memory
// itself is not reset. Only the read register is, so the output is known
// from reset on. A read and a write to the same slot in one cycle return
// the old content.
module rxb_store #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [PTR_W-1:0]  raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Store the incoming word at the selected slot.
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Capture the oldest word on a pop, otherwise hold the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem_q[raddr];
        end
    end

endmodule

// File: rtl/rxb_flags.sv
// Module: rxb_flags
// Produces the data-ready flag and the occupancy status bits. Assumes the
// count comes from a register, so the status outputs change right after
// the clock edge that changes the count.
module rxb_flags
    import rxb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rxb_op_t          op,
    input  logic [CNT_W-1:0] cnt_q,
    output logic             data_rdy,
    output logic             sts_vacant,
    output logic             sts_half,
    output logic             sts_full
);

    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DEPTH / 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    // Set data-ready on any write, clear it when a pop takes the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_rdy <= 1'b0;
        end else if (op.push || op.over) begin
            data_rdy <= 1'b1;
        end else if (op.pop && cnt_q == CNT_W'(1)) begin
            data_rdy <= 1'b0;
        end
    end

    // Occupancy status bits from the stored count.
    always_comb begin
        sts_vacant = (cnt_q == '0);
        sts_half   = (cnt_q >= CNT_HALF);
        sts_full   = (cnt_q == CNT_FULL);
    end

endmodule

// File: rtl/rx_word_buffer.sv
// Module: rx_word_buffer
// Buffer for received data words with occupancy status. A write while
// full replaces the newest word. A pop while empty is ignored. Assumes
// DEPTH is a power of two and at least 2, and that strobes are synchronous
// to clk.
module rx_word_buffer
    import rxb_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [WORD_W-1:0] rd_data,
    output logic [CNT_W-1:0]  word_count,
    output logic              data_rdy,
    output logic              sts_vacant,
    output logic              sts_half,
    output logic              sts_full
);

    rxb_op_t          op;
    logic [PTR_W-1:0] waddr;
    logic [PTR_W-1:0] raddr;
    logic [CNT_W-1:0] cnt_q;

    rxb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .rd_stb (rd_stb),
        .op     (op),
        .waddr  (waddr),
        .raddr  (raddr),
        .cnt_q  (cnt_q)
    );

    rxb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op.push || op.over),
        .waddr (waddr),
        .wdata (wr_data),
        .re    (op.pop),
        .raddr (raddr),
        .rdata (rd_data)
    );

    rxb_flags #(.DEPTH(DEPTH)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .op         (op),
        .cnt_q      (cnt_q),
        .data_rdy   (data_rdy),
        .sts_vacant (sts_vacant),
        .sts_half   (sts_half),
        .sts_full   (sts_full)
    );

    // Bring the count out at the ports.
    always_comb begin
        word_count = cnt_q;
    end

endmodule

// File: rtl/rxb_checker.sv
// Module: rxb_checker
// Property checks on the ports of rx_word_buffer, attached with bind.
module rxb_checker #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic [WORD_W-1:0] wr_data,
    input logic              rd_stb,
    input logic [WORD_W-1:0] rd_data,
    input logic [CNT_W-1:0]  word_count,
    input logic              data_rdy,
    input logic              sts_vacant,
    input logic              sts_half,
    input logic              sts_full
);

    a_r2_write_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> data_rdy);

    a_r3_vacant_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        sts_vacant == (word_count == '0));

    a_r5_last_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == CNT_W'(1) && rd_stb && !wr_stb) |=> (!data_rdy && sts_vacant));

    a_r6_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '0 && rd_stb && !wr_stb) |=> ($stable(rd_data) && word_count == '0));

    a_r7_half_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        sts_half == (word_count >= CNT_W'(DEPTH / 2)));

    a_r9_full_write_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_full && wr_stb && !rd_stb) |=> (sts_full && $stable(word_count)));

    a_r10_both_strobes_hold_count: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && rd_stb && word_count != '0) |=> $stable(word_count));

    // R12: the count never exceeds the depth.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            a_r12_no_overflow: assert (word_count <= CNT_W'(DEPTH));
        end
    end

endmodule

bind rx_word_buffer rxb_checker #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/rx_word_buffer_test.sv
// Directed bench for rx_word_buffer: one task per scenario, each checking
// its own results against a queue model.
module rx_word_buffer_test;

    localparam int CLK_P = 10;
    localparam int W     = 32;
    localparam int D     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [W-1:0]  wr_data = '0;
    logic          rd_stb = 1'b0;
    logic [W-1:0]  rd_data;
    logic [5:0]    word_count;
    logic          data_rdy, sts_vacant, sts_half, sts_full;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] mdl[$];

    always #(CLK_P / 2) clk = ~clk;

    rx_word_buffer uut (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rd_data(rd_data), .word_count(word_count),
        .data_rdy(data_rdy), .sts_vacant(sts_vacant), .sts_half(sts_half),
        .sts_full(sts_full)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock cycle with the given strobes; the model follows the requirements.
    task automatic cycle(input logic wr, input logic rd, input logic [W-1:0] d);
        @(negedge clk);
        wr_stb  = wr;
        rd_stb  = rd;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
    endtask

    task automatic push(input logic [W-1:0] d);
        cycle(1'b1, 1'b0, d);
        if (mdl.size() == D) mdl[D-1] = d;
        else mdl.push_back(d);
    endtask

    task automatic pop_chk(input string req);
        logic [W-1:0] e;
        e = mdl.pop_front();
        cycle(1'b0, 1'b1, '0);
        chk(req, rd_data, e);
    endtask

    task automatic status_chk(input string req);
        chk({req, " count R12"}, word_count, mdl.size());
        chk({req, " vacant R3"}, sts_vacant, mdl.size() == 0);
        chk({req, " half R7"}, sts_half, mdl.size() >= D / 2);
        chk({req, " full R8"}, sts_full, mdl.size() == D);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mdl.delete();
        chk("R1 count", word_count, 0);
        chk("R1 data_rdy", data_rdy, 0);
        chk("R1 vacant", sts_vacant, 1);
        chk("R1 half", sts_half, 0);
        chk("R1 full", sts_full, 0);
    endtask

    task automatic t_single;
        push(32'hA5A5_0001);
        chk("R2 ready after write", data_rdy, 1);
        chk("R3 vacant low", sts_vacant, 0);
        pop_chk("R4 single word");
        chk("R5 ready cleared", data_rdy, 0);
        chk("R3 vacant high", sts_vacant, 1);
    endtask

    task automatic t_empty_pop;
        logic [W-1:0] prev;
        prev = rd_data;
        cycle(1'b0, 1'b1, '0);
        chk("R6 rd_data held", rd_data, prev);
        chk("R6 count held", word_count, 0);
        // Pop ignored while empty even with a write: one word results.
        cycle(1'b1, 1'b1, 32'h0000_BEEF);
        mdl.push_back(32'h0000_BEEF);
        chk("R6 rd_data held with write", rd_data, prev);
        chk("R6 count one", word_count, 1);
        pop_chk("R4 after empty pop");
    endtask

    task automatic t_fill;
        for (int i = 0; i < D; i++) begin
            push(32'h1000_0000 + i);
            if (i == 14 || i == 15 || i == 30 || i == 31) status_chk("fill R7 R8");
        end
    endtask

    task automatic t_overwrite;
        push(32'hDEAD_0001);
        chk("R9 count stays", word_count, D);
        chk("R2 ready at full write", data_rdy, 1);
        push(32'hDEAD_0002);
        status_chk("R9 after overwrite");
        for (int i = 0; i < D; i++) pop_chk("R9 drain order");
        status_chk("R9 drained");
        chk("R5 ready after drain", data_rdy, 0);
    endtask

    task automatic t_both_partial;
        for (int i = 0; i < 5; i++) push(32'h2000_0000 + i);
        for (int i = 0; i < 3; i++) begin
            logic [W-1:0] e;
            e = mdl.pop_front();
            mdl.push_back(32'h3000_0000 + i);
            cycle(1'b1, 1'b1, 32'h3000_0000 + i);
            chk("R10 oldest out", rd_data, e);
            chk("R10 count held", word_count, 5);
        end
        while (mdl.size() > 0) pop_chk("R10 order after both");
    endtask

    task automatic t_both_full;
        logic [W-1:0] e;
        for (int i = 0; i < D; i++) push(32'h4000_0000 + i);
        e = mdl.pop_front();
        mdl.push_back(32'h5555_AAAA);
        cycle(1'b1, 1'b1, 32'h5555_AAAA);
        chk("R11 oldest out", rd_data, e);
        chk("R11 count held", word_count, D);
        chk("R11 full held", sts_full, 1);
        while (mdl.size() > 0) pop_chk("R11 order after both at full");
        status_chk("R11 drained");
    endtask

    initial begin
        t_reset();
        t_single();
        t_empty_pop();
        t_fill();
        t_overwrite();
        t_both_partial();
        t_both_full();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule